// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block sits between the core of an 8-bit controller and the pins of its external memory bus. The core hands it one request at a time. A request is an instruction fetch, a data read or a data write, and it comes with a 16-bit address. The block runs each request as one machine cycle of twelve clock phases, T1 to T12. During the cycle it drives the address latch strobe, the active-low program store, read and write strobes, the high address byte, and a low port that carries the low address byte first and the data byte after it.

Fetches can also be served from on-chip ROM. When the external-access input is high and the fetch address lies below the ROM size (4096 bytes by default), the byte comes from the internal ROM and the program store strobe stays high. Otherwise the fetch goes to the external bus. Data accesses always use the external bus. Their high address byte is either the upper half of the 16-bit pointer or the current port 2 latch value, depending on the addressing form the core used.

A request that arrives in T12 starts the next cycle with no idle clock in between. A single-cycle done pulse marks the end of every access. Read data is held on `rdata_o` until the next capture.

Top module: `xbus_seq`

## Requirements
- R1: A request accepted at a clock edge starts T1 in the following cycle. `done_o` is high for exactly one cycle, during T12. A request seen while idle or in T12 is accepted.
- R2: On external accesses `ale_o` is high in T1 and T2 only. The low port drives the address low byte (`lo_oe_o` = 1) in T1 to T3.
- R3: The low port floats (`lo_oe_o` = 0) in T4 of every access, and from T4 to T12 of external fetches and reads.
- R4: `psen_no` is low in T5 to T11 of external fetches and high at all other times.
- R5: `rd_no` is low in T6 to T11 of reads and `wr_no` is low in T6 to T11 of writes. At most one of the three strobes is low at any time, and all are high in reset and while idle.
- R6: During a write the low port drives the write byte in T5 to T12.
- R7: Encoding of `kind_i`: 0 is a fetch, 1 is a read, 2 is a write, and 3 is treated as a read. A fetch is internal exactly when `ea_i` = 1 and the address is below ROM_BYTES. Reads and writes are never internal.
- R8: `hi_port_o` carries address bits 15:8 on external fetches and on data accesses with `use_dptr_i` = 1. It carries the port 2 latch value captured at acceptance on other data accesses and on internal fetches. While idle it follows `p2_latch_i`.
- R9: Fetch and read data are captured at the clock edge that ends T11. `rdata_o` keeps its previous value through T11, shows the new byte from T12 on, and does not change on writes.
- R10: An internal fetch leaves `psen_no` high and the low port floating. It raises `rom_en_o` in T11 only, with `rom_addr_o` equal to the low address bits, and returns `rom_data_i`.
- R11: With INT_ALE = 1, `ale_o` pulses in T1 and T2 of internal fetches as well. With INT_ALE = 0 it stays low during internal fetches.
- R12: A request raised in T2 to T11 of a running access is ignored. The running access completes unchanged and no extra access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one period per phase |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request from the core |
| kind_i | input | 2 | Access kind (0 fetch, 1 read, 2 write) |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write byte |
| use_dptr_i | input | 1 | Data access uses the 16-bit pointer |
| p2_latch_i | input | 8 | Current port 2 latch value |
| ea_i | input | 1 | External-access select; high enables internal ROM |
| rom_data_i | input | 8 | Byte returned by internal ROM |
| lo_port_i | input | 8 | Value sensed on the multiplexed low port |
| ale_o | output | 1 | Address latch strobe |
| psen_no | output | 1 | Program store enable, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| hi_port_o | output | 8 | High address / port 2 output |
| lo_port_o | output | 8 | Multiplexed low address / data output |
| lo_oe_o | output | 1 | Output enable of the low port |
| rom_en_o | output | 1 | Internal ROM read enable |
| rom_addr_o | output | 12 | Internal ROM address |
| rdata_o | output | 8 | Captured read or fetch byte |
| done_o | output | 1 | End-of-access pulse |

## Verification
The hardest situations to reach are the two ends of a machine cycle. One is a new request landing exactly in T12, which must chain without an idle clock. The other is a stray request in the middle of a cycle, which must leave the running cycle untouched. The driver sets up both. It raises the next request at the sampling point inside T12, and in one access it pulses a conflicting write request in T6 while phase-by-phase checks continue. The fetch-source boundary is covered with fetches at 0x0FFF and 0x1000 under `ea_i` high, and at a low address under `ea_i` low.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  // fixed phase landmarks (zero based: 0 is T1)
  localparam int PH_ALE_LAST  = 1;
  localparam int PH_ADR_LAST  = 2;
  localparam int PH_PSEN_FRST = 4;
  localparam int PH_STB_FRST  = 5;
  localparam int PH_WDAT_FRST = 4;

  typedef struct packed {
    acc_kind_e           kind;
    logic                internal;
    logic                use_dptr;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   wdata;
    logic [DATA_W-1:0]   p2;
  } xbus_req_t;
endpackage

// File: rtl/xbus_phase_ctr.sv
`timescale 1ns/1ps
module xbus_phase_ctr #(
  parameter int PHASES = 12,
  parameter int PW     = $clog2(PHASES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [PW-1:0] ph_o,
  output logic          last_o
);
  localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);

  logic          busy_q, busy_d;
  logic [PW-1:0] ph_q, ph_d;
  logic          adv_en;

  assign last_o = busy_q && (ph_q == LAST_PH);
  assign adv_en = busy_q && !last_o;

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    if (start_i) begin
      busy_d = 1'b1;
      ph_d   = '0;
    end else if (last_o) begin
      busy_d = 1'b0;
    end else if (adv_en) begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
    end
  end

  assign busy_o = busy_q;
  assign ph_o   = ph_q;
endmodule

// File: rtl/xbus_src_sel.sv
`timescale 1ns/1ps
module xbus_src_sel
  import xbus_pkg::*;
#(
  parameter int ROM_BYTES = 4096
) (
  input  acc_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ea_i,
  output logic              internal_o
);
  localparam logic [ADDR_W:0] ROM_LIMIT = (ADDR_W + 1)'(ROM_BYTES);

  logic below_limit;
  assign below_limit = ({1'b0, addr_i} < ROM_LIMIT);
  assign internal_o  = (kind_i == ACC_FETCH) && ea_i && below_limit;
endmodule

// File: rtl/xbus_strobe_gen.sv
`timescale 1ns/1ps
module xbus_strobe_gen
  import xbus_pkg::*;
#(
  parameter int PHASES  = 12,
  parameter int PW      = $clog2(PHASES),
  parameter bit INT_ALE = 1'b1
) (
  input  logic          busy_i,
  input  logic [PW-1:0] ph_i,
  input  acc_kind_e     kind_i,
  input  logic          internal_i,
  output logic          ale_o,
  output logic          psen_no,
  output logic          rd_no,
  output logic          wr_no,
  output logic          addr_phase_o,
  output logic          wdata_phase_o,
  output logic          lo_oe_o,
  output logic          cap_o,
  output logic          rom_en_o,
  output logic          done_o
);
  localparam logic [PW-1:0] CAP_PH   = PW'(PHASES - 2);
  localparam logic [PW-1:0] LAST_PH  = PW'(PHASES - 1);
  localparam logic [PW-1:0] ALE_LAST = PW'(PH_ALE_LAST);
  localparam logic [PW-1:0] ADR_LAST = PW'(PH_ADR_LAST);
  localparam logic [PW-1:0] PSEN_FR  = PW'(PH_PSEN_FRST);
  localparam logic [PW-1:0] STB_FR   = PW'(PH_STB_FRST);
  localparam logic [PW-1:0] WDAT_FR  = PW'(PH_WDAT_FRST);

  logic ext_act;
  logic ale_gate;
  logic in_ale, in_adr, in_psen, in_stb, in_wdat;

  assign ext_act = busy_i && !internal_i;

  generate
    if (INT_ALE) begin : g_ale_always
      assign ale_gate = 1'b1;
    end else begin : g_ale_ext_only
      assign ale_gate = !internal_i;
    end
  endgenerate

  assign in_ale  = (ph_i <= ALE_LAST);
  assign in_adr  = (ph_i <= ADR_LAST);
  assign in_psen = (ph_i >= PSEN_FR) && (ph_i <= CAP_PH);
  assign in_stb  = (ph_i >= STB_FR) && (ph_i <= CAP_PH);
  assign in_wdat = (ph_i >= WDAT_FR);

  always_comb begin
    ale_o         = busy_i && in_ale && ale_gate;
    psen_no       = !(ext_act && (kind_i == ACC_FETCH) && in_psen);
    rd_no         = !(ext_act && (kind_i == ACC_READ) && in_stb);
    wr_no         = !(ext_act && (kind_i == ACC_WRITE) && in_stb);
    addr_phase_o  = ext_act && in_adr;
    wdata_phase_o = ext_act && (kind_i == ACC_WRITE) && in_wdat;
    lo_oe_o       = addr_phase_o || wdata_phase_o;
    cap_o         = busy_i && (kind_i != ACC_WRITE) && (ph_i == CAP_PH);
    rom_en_o      = busy_i && internal_i && (ph_i == CAP_PH);
    done_o        = busy_i && (ph_i == LAST_PH);
  end
endmodule

// File: rtl/xbus_port_mux.sv
`timescale 1ns/1ps
module xbus_port_mux
  import xbus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  xbus_req_t         cur_i,
  input  logic [DATA_W-1:0] p2_live_i,
  input  logic              addr_phase_i,
  input  logic              wdata_phase_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] rom_data_i,
  input  logic [DATA_W-1:0] lo_port_i,
  output logic [DATA_W-1:0] hi_port_o,
  output logic [DATA_W-1:0] lo_port_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              hi_from_addr;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              cap_en;

  assign hi_from_addr = busy_i && !cur_i.internal &&
                        ((cur_i.kind == ACC_FETCH) || cur_i.use_dptr);

  always_comb begin
    if (hi_from_addr)  hi_port_o = cur_i.addr[ADDR_W-1:ADDR_W-DATA_W];
    else if (busy_i)   hi_port_o = cur_i.p2;
    else               hi_port_o = p2_live_i;
  end

  always_comb begin
    if (addr_phase_i)       lo_port_o = cur_i.addr[DATA_W-1:0];
    else if (wdata_phase_i) lo_port_o = cur_i.wdata;
    else                    lo_port_o = '0;
  end

  assign cap_en  = cap_i;
  assign rdata_d = cur_i.internal ? rom_data_i : lo_port_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (cap_en) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int PHASES    = 12,
  parameter int ROM_BYTES = 4096,
  parameter bit INT_ALE   = 1'b1,
  parameter int RAW       = $clog2(ROM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              use_dptr_i,
  input  logic [DATA_W-1:0] p2_latch_i,
  input  logic              ea_i,
  input  logic [DATA_W-1:0] rom_data_i,
  input  logic [DATA_W-1:0] lo_port_i,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [DATA_W-1:0] hi_port_o,
  output logic [DATA_W-1:0] lo_port_o,
  output logic              lo_oe_o,
  output logic              rom_en_o,
  output logic [RAW-1:0]    rom_addr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  localparam int PW = $clog2(PHASES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic          busy, last, start;
  logic [PW-1:0] ph;
  acc_kind_e     kind_dec;
  logic          new_internal;
  xbus_req_t     cur_q, cur_d;
  logic          addr_phase, wdata_phase, cap;

  always_comb begin
    unique case (kind_i)
      2'd0:    kind_dec = ACC_FETCH;
      2'd2:    kind_dec = ACC_WRITE;
      default: kind_dec = ACC_READ;
    endcase
  end

  assign start = req_i && (!busy || last);

  xbus_src_sel #(.ROM_BYTES(ROM_BYTES)) u_src (
    .kind_i     (kind_dec),
    .addr_i     (addr_i),
    .ea_i       (ea_i),
    .internal_o (new_internal)
  );

  always_comb begin
    cur_d          = cur_q;
    cur_d.kind     = kind_dec;
    cur_d.internal = new_internal;
    cur_d.use_dptr = use_dptr_i;
    cur_d.addr     = addr_i;
    cur_d.wdata    = wdata_i;
    cur_d.p2       = p2_latch_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)     cur_q <= '0;
    else if (start) cur_q <= cur_d;
  end

  xbus_phase_ctr #(.PHASES(PHASES), .PW(PW)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (start),
    .busy_o  (busy),
    .ph_o    (ph),
    .last_o  (last)
  );

  xbus_strobe_gen #(.PHASES(PHASES), .PW(PW), .INT_ALE(INT_ALE)) u_stb (
    .busy_i        (busy),
    .ph_i          (ph),
    .kind_i        (cur_q.kind),
    .internal_i    (cur_q.internal),
    .ale_o         (ale_o),
    .psen_no       (psen_no),
    .rd_no         (rd_no),
    .wr_no         (wr_no),
    .addr_phase_o  (addr_phase),
    .wdata_phase_o (wdata_phase),
    .lo_oe_o       (lo_oe_o),
    .cap_o         (cap),
    .rom_en_o      (rom_en_o),
    .done_o        (done_o)
  );

  xbus_port_mux u_mux (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .busy_i        (busy),
    .cur_i         (cur_q),
    .p2_live_i     (p2_latch_i),
    .addr_phase_i  (addr_phase),
    .wdata_phase_i (wdata_phase),
    .cap_i         (cap),
    .rom_data_i    (rom_data_i),
    .lo_port_i     (lo_port_i),
    .hi_port_o     (hi_port_o),
    .lo_port_o     (lo_port_o),
    .rdata_o       (rdata_o)
  );

  assign rom_addr_o = cur_q.addr[RAW-1:0];
endmodule

// File: rtl/xbus_seq_chk.sv
`timescale 1ns/1ps
module xbus_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ale_o,
  input logic       psen_no,
  input logic       rd_no,
  input logic       wr_no,
  input logic       lo_oe_o,
  input logic       rom_en_o,
  input logic [7:0] rdata_o,
  input logic       done_o
);
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~psen_no, ~rd_no, ~wr_no}) <= 1);                          // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                                    // R1
  AST_ALE_QUIET_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (psen_no && rd_no && wr_no));                                 // R2
  AST_READ_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !psen_no) |-> !lo_oe_o);                                     // R3
  AST_WRITE_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> lo_oe_o);                                                    // R6
  AST_PSEN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(psen_no) |-> ($past(psen_no, 7) == 1'b0));                        // R4
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> $past(!psen_no || !rd_no || rom_en_o));           // R9
  AST_ROM_QUIET_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en_o |-> (psen_no && !lo_oe_o));                                    // R10
endmodule

bind xbus_seq xbus_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ale_o    (ale_o),
  .psen_no  (psen_no),
  .rd_no    (rd_no),
  .wr_no    (wr_no),
  .lo_oe_o  (lo_oe_o),
  .rom_en_o (rom_en_o),
  .rdata_o  (rdata_o),
  .done_o   (done_o)
);

// File: tb/sim_xbus_seq.sv
`timescale 1ns/1ps
module sim_xbus_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [1:0]  kind;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        dptr;
  logic [7:0]  p2;
  logic        ea;
  logic [7:0]  rom_data;
  logic [7:0]  lo_in;
  logic        ale, psen_n, rd_n, wr_n, lo_oe, rom_en, done;
  logic [7:0]  hi_out, lo_out, rdata;
  logic [11:0] rom_addr;
  logic        ale1, psen1, rd1, wr1, oe1, rom_en1, done1;
  logic [7:0]  hi1, lo1, rdata1;
  logic [11:0] rom_addr1;

  always #10 clk = ~clk;

  function automatic logic [7:0] rom_fn(input logic [11:0] a);
    return {a[3:0], a[11:8]} ^ a[7:0] ^ 8'hA5;
  endfunction
  assign rom_data = rom_fn(rom_addr);

  xbus_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .addr_i(addr),
    .wdata_i(wdata), .use_dptr_i(dptr), .p2_latch_i(p2), .ea_i(ea),
    .rom_data_i(rom_data), .lo_port_i(lo_in), .ale_o(ale), .psen_no(psen_n),
    .rd_no(rd_n), .wr_no(wr_n), .hi_port_o(hi_out), .lo_port_o(lo_out),
    .lo_oe_o(lo_oe), .rom_en_o(rom_en), .rom_addr_o(rom_addr),
    .rdata_o(rdata), .done_o(done)
  );

  xbus_seq #(.INT_ALE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .addr_i(addr),
    .wdata_i(wdata), .use_dptr_i(dptr), .p2_latch_i(p2), .ea_i(ea),
    .rom_data_i(rom_data), .lo_port_i(lo_in), .ale_o(ale1), .psen_no(psen1),
    .rd_no(rd1), .wr_no(wr1), .hi_port_o(hi1), .lo_port_o(lo1),
    .lo_oe_o(oe1), .rom_en_o(rom_en1), .rom_addr_o(rom_addr1),
    .rdata_o(rdata1), .done_o(done1)
  );

  int         nvec = 0;
  int         nfail = 0;
  bit         mon_en = 1'b0;
  bit         finished = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] last_rdata = 8'h00;
  logic [7:0] mon_exp;

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: one expected byte per completed access
  always @(negedge clk) begin
    if (mon_en && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R12", "done without pending access", 1, 0);
      end else begin
        mon_exp = exp_q.pop_front();
        chk(rdata == mon_exp, "R9", "rdata at done", rdata, mon_exp);
      end
    end
  end

  task automatic idle_check();
    @(negedge clk);
    chk(psen_n && rd_n && wr_n, "R5", "idle strobes", {psen_n, rd_n, wr_n}, 3'b111);
    chk(!ale && !lo_oe && !done, "R1", "idle ale/oe/done", {ale, lo_oe, done}, 0);
    chk(hi_out == p2, "R8", "idle high port", hi_out, p2);
  endtask

  // drives one access; returns at the sampling point inside T12
  task automatic run(input logic [1:0] k_kind, input logic [15:0] a,
                     input logic [7:0] wd, input bit dp, input bit e, input bit mid);
    bit         intl;
    bit         is_f, is_r, is_w;
    logic [7:0] ext_b, exp_rd, hi_e;
    is_f  = (k_kind == 2'd0);
    is_w  = (k_kind == 2'd2);
    is_r  = !is_f && !is_w;
    intl  = is_f && e && (a < 16'h1000);
    ext_b = a[7:0] ^ a[15:8] ^ 8'h3C;
    exp_rd = is_w ? last_rdata : (intl ? rom_fn(a[11:0]) : ext_b);
    hi_e  = (!intl && (is_f || dp)) ? a[15:8] : p2;
    kind = k_kind; addr = a; wdata = wd; dptr = dp; ea = e; lo_in = ext_b; req = 1'b1;
    exp_q.push_back(exp_rd);
    for (int k = 1; k <= 12; k++) begin
      bit ale_e, psen_lo, rd_lo, wr_lo, oe_e;
      @(negedge clk);
      ale_e   = (k <= 2);
      psen_lo = is_f && !intl && (k >= 5) && (k <= 11);
      rd_lo   = is_r && (k >= 6) && (k <= 11);
      wr_lo   = is_w && (k >= 6) && (k <= 11);
      oe_e    = !intl && ((k <= 3) || (is_w && k >= 5));
      chk(ale == ale_e, intl ? "R11" : "R2", $sformatf("ale T%0d", k), ale, ale_e);
      chk(ale1 == (ale_e && !intl), "R11", $sformatf("ale no-int T%0d", k), ale1, ale_e && !intl);
      chk(psen_n == !psen_lo, intl ? "R10" : "R4", $sformatf("psen T%0d", k), psen_n, !psen_lo);
      chk(rd_n == !rd_lo, "R5", $sformatf("rd T%0d", k), rd_n, !rd_lo);
      chk(wr_n == !wr_lo, "R5", $sformatf("wr T%0d", k), wr_n, !wr_lo);
      chk(lo_oe == oe_e, (k == 4) ? "R3" : "R2", $sformatf("oe T%0d", k), lo_oe, oe_e);
      if (oe_e && k <= 3)
        chk(lo_out == a[7:0], "R2", $sformatf("low addr T%0d", k), lo_out, a[7:0]);
      if (oe_e && k >= 5)
        chk(lo_out == wd, "R6", $sformatf("write byte T%0d", k), lo_out, wd);
      chk(hi_out == hi_e, "R8", $sformatf("high port T%0d", k), hi_out, hi_e);
      chk(rom_en == (intl && k == 11), "R7", $sformatf("rom_en T%0d", k), rom_en, intl && k == 11);
      chk(done == (k == 12), "R1", $sformatf("done T%0d", k), done, k == 12);
      if (intl && k == 11)
        chk(rom_addr == a[11:0], "R10", "rom address", rom_addr, a[11:0]);
      if (k == 11)
        chk(rdata == last_rdata, "R9", "rdata held in T11", rdata, last_rdata);
      if (k == 1) req = 1'b0;
      if (mid && k == 6) begin req = 1'b1; addr = 16'hFFFF; kind = 2'd2; end
      if (mid && k == 7) req = 1'b0;
    end
    last_rdata = exp_rd;
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; kind = 2'd0; addr = '0; wdata = '0;
    dptr = 1'b0; p2 = 8'h5D; ea = 1'b0; lo_in = '0;
    repeat (4) @(negedge clk);
    chk(psen_n && rd_n && wr_n, "R5", "reset strobes", {psen_n, rd_n, wr_n}, 3'b111);
    chk(!ale && !lo_oe && !done, "R1", "reset ale/oe/done", {ale, lo_oe, done}, 0);
    chk(rdata == 8'h00, "R9", "reset rdata", rdata, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    idle_check();

    run(2'd0, 16'h0123, 8'h00, 1'b0, 1'b0, 1'b0);   // R7 EA low: external fetch
    idle_check();
    run(2'd0, 16'h0FFF, 8'h00, 1'b0, 1'b1, 1'b0);   // R7 R10 top of ROM
    idle_check();
    run(2'd0, 16'h1000, 8'h00, 1'b0, 1'b1, 1'b0);   // R7 first external address
    idle_check();
    run(2'd1, 16'h8A55, 8'h00, 1'b1, 1'b1, 1'b0);   // read through pointer
    idle_check();
    p2 = 8'hC3;
    run(2'd1, 16'h0077, 8'h00, 1'b0, 1'b0, 1'b0);   // R8 register-indirect read
    idle_check();
    run(2'd2, 16'h4321, 8'h9E, 1'b1, 1'b0, 1'b0);   // R6 write through pointer
    idle_check();
    run(2'd2, 16'h0011, 8'h61, 1'b0, 1'b0, 1'b0);   // R6 R8 indirect write
    // R1 back-to-back chain starting in T12
    run(2'd0, 16'h0200, 8'h00, 1'b0, 1'b1, 1'b0);
    run(2'd3, 16'hF00D, 8'h00, 1'b1, 1'b1, 1'b0);
    run(2'd0, 16'hBEEF, 8'h00, 1'b0, 1'b1, 1'b0);
    idle_check();
    run(2'd1, 16'h3344, 8'h00, 1'b1, 1'b0, 1'b1);   // R12 stray request in T6
    idle_check();
    idle_check();
    chk(exp_q.size() == 0, "R12", "pending accesses at end", exp_q.size(), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule